// File: doc/BRIEF.md
# Timer Bank Register Front End

This block is the software-facing register layer for a bank of eight timer channels. A simple valid/write/address/data port reaches per-channel registers (live count, reload value, two match thresholds) together with a shared control word and a second, inert control word. The counters themselves sit outside the block. They see the stored reload and match values and the per-channel configuration bits. They receive a one-cycle load strobe when software writes a count, and they return their live counts for read-back.

The shared control word holds a four-bit nibble for each channel. A control write is applied in a fixed three-step order:
- Channels that are switched off are stopped first.
- The remaining configuration bits change next.
- Channels that are switched on are started last.

Each step occupies its own clock cycle. The counting logic therefore never sees a channel run while its configuration is half old and half new.

Top module: `timer_bank_regs`

## Requirements
- R1: Word offsets below 0x30 select channel `offset>>4`. Offsets 0x40 to 0x8F select channel `(offset>>4)-1`. Within a channel, +0x0 is the count, +0x4 the reload, +0x8 the first match and +0xC the second match. Reload and match writes appear on that channel's output slice after the write edge and read back unchanged. `bus_rdata` shows read data in the cycle after the access and holds it until the next read.
- R2: A write to a count register pulses `cnt_load` for that channel alone, for one cycle starting after the write edge, with `cnt_load_val` equal to the written data. A read of a count register returns `cnt_live` for that channel as sampled at the access edge.
- R3: The control word at offset 0x30 gives channel i bits 4i..4i+3: bit 4i run, bit 4i+1 external clock select, bit 4i+2 overflow interrupt enable, bit 4i+3 pulse mode. It reads back as stored.
- R4: Pulse-mode bits for channels 0 to 3 (word bits 3, 7, 11, 15) are discarded: they read back as 0, `pulse_en` stays 0 for those channels, and `bus_err` pulses for one cycle.
- R5: For a channel whose run bit falls, `run_en` falls and `stop_stb` pulses in the cycle after the write edge. The configuration outputs still hold their old values in that cycle.
- R6: The configuration outputs (`clk_ext`, `ovf_irq_en`, `pulse_en`) take their new values two cycles after the write edge. For a channel whose run bit rises, `run_en` rises and `start_stb` pulses one cycle after that.
- R7: The second control word at offset 0x34 is stored and read back and changes no output.
- R8: An access to offset 0x38, 0x3C, 0x90 or above, or to an address with either low bit set, reads as 0, writes nothing, and pulses `bus_err` for one cycle after the access edge.
- R9: After reset all stored registers read 0, and all channel outputs, strobes, `bus_rdata` and `bus_err` are 0.
- R10: Rewriting a control word without changing a channel's run bit gives no `start_stb` or `stop_stb` for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle flag for a bad access or a rejected pulse bit |
| cnt_live | input | 256 | Live count of each channel, 32 bits per channel |
| cnt_load | output | 8 | Per-channel count load strobe |
| cnt_load_val | output | 32 | Value to load with `cnt_load` |
| reload_val | output | 256 | Reload value of each channel |
| match1_val | output | 256 | First match threshold of each channel |
| match2_val | output | 256 | Second match threshold of each channel |
| run_en | output | 8 | Applied run state of each channel |
| clk_ext | output | 8 | Applied external clock select |
| ovf_irq_en | output | 8 | Applied overflow interrupt enable |
| pulse_en | output | 8 | Applied pulse mode |
| start_stb | output | 8 | One-cycle start strobe per channel |
| stop_stb | output | 8 | One-cycle stop strobe per channel |

## Verification
The sequencing assertions assume that consecutive control-word writes are at least four cycles apart, so that each write's stop, configure and start steps finish before the next write begins. The bench satisfies this because its control-write task waits through all three steps before it returns. The address checks need only word-sized accesses presented for a single cycle. The random stimulus draws offsets from the whole 8-bit window, including misaligned and unmapped ones. A live count is changed only between accesses, so the value a count read must return is known when the access is issued.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  typedef enum logic [1:0] {
    ACC_CHAN  = 2'd0,
    ACC_CTRL  = 2'd1,
    ACC_CTRL2 = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLD_COUNT  = 2'd0,
    FLD_RELOAD = 2'd1,
    FLD_MATCH1 = 2'd2,
    FLD_MATCH2 = 2'd3
  } chan_fld_e;

  localparam int NIB_W     = 4;
  localparam int BIT_RUN   = 0;
  localparam int BIT_EXT   = 1;
  localparam int BIT_OVF   = 2;
  localparam int BIT_PULSE = 3;
  localparam int BLK_BYTES = 16;

  // mask of the pulse bits belonging to channels that may not use pulse mode
  function automatic logic [31:0] low_pulse_mask(input int first_capable);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 8; i++)
      if (i < first_capable) m[i*NIB_W + BIT_PULSE] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tbr_addr_decode.sv
module tbr_addr_decode
  import tbr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NCH        = 8,
  parameter int LOW_BLOCKS = 3,
  localparam int CH_W      = $clog2(NCH)
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [CH_W-1:0]   ch,
  output chan_fld_e         fld
);
  localparam int CTRL_OFF  = LOW_BLOCKS * BLK_BYTES;
  localparam int CTRL2_OFF = CTRL_OFF + 4;
  localparam int HIGH_BASE = CTRL_OFF + BLK_BYTES;
  localparam int HIGH_END  = HIGH_BASE + (NCH - LOW_BLOCKS) * BLK_BYTES;

  int a;
  int blk;

  always_comb begin
    a    = int'(addr);
    blk  = a / BLK_BYTES;
    kind = ACC_BAD;
    ch   = '0;
    fld  = chan_fld_e'(addr[3:2]);
    if (addr[1:0] != 2'b00) begin
      kind = ACC_BAD;
    end else if (a < CTRL_OFF) begin
      kind = ACC_CHAN;
      ch   = CH_W'(blk);
    end else if (a == CTRL_OFF) begin
      kind = ACC_CTRL;
    end else if (a == CTRL2_OFF) begin
      kind = ACC_CTRL2;
    end else if (a >= HIGH_BASE && a < HIGH_END) begin
      kind = ACC_CHAN;
      ch   = CH_W'(blk - 1);
    end
  end
endmodule

// File: rtl/tbr_chan_file.sv
module tbr_chan_file
  import tbr_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] sel_ch,
  input  chan_fld_e       sel_fld,
  input  logic [DW-1:0]   wdata,
  input  logic [NCH*DW-1:0] cnt_live,
  output logic [NCH*DW-1:0] reload_flat,
  output logic [NCH*DW-1:0] match1_flat,
  output logic [NCH*DW-1:0] match2_flat,
  output logic [NCH-1:0]    cnt_load,
  output logic [DW-1:0]     cnt_load_val,
  output logic [DW-1:0]     rd_word
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = wr_en && (sel_ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        reload_flat[g*DW +: DW] <= '0;
        match1_flat[g*DW +: DW] <= '0;
        match2_flat[g*DW +: DW] <= '0;
        cnt_load[g]             <= 1'b0;
      end else begin
        cnt_load[g] <= hit && (sel_fld == FLD_COUNT);
        if (hit && sel_fld == FLD_RELOAD) reload_flat[g*DW +: DW] <= wdata;
        if (hit && sel_fld == FLD_MATCH1) match1_flat[g*DW +: DW] <= wdata;
        if (hit && sel_fld == FLD_MATCH2) match2_flat[g*DW +: DW] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_load_val <= '0;
    else if (wr_en && sel_fld == FLD_COUNT) cnt_load_val <= wdata;
  end

  always_comb begin
    unique case (sel_fld)
      FLD_COUNT:  rd_word = cnt_live[sel_ch*DW +: DW];
      FLD_RELOAD: rd_word = reload_flat[sel_ch*DW +: DW];
      FLD_MATCH1: rd_word = match1_flat[sel_ch*DW +: DW];
      default:    rd_word = match2_flat[sel_ch*DW +: DW];
    endcase
  end

  a_r2_load_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cnt_load));
  a_r2_load_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_fld == FLD_COUNT) |=> ($countones(cnt_load) == 1));
  a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(reload_flat) && $stable(match1_flat) && $stable(match2_flat)));
endmodule

// File: rtl/tbr_ctrl_seq.sv
module tbr_ctrl_seq
  import tbr_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 32,
  parameter int PULSE_FIRST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_ctrl2,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_word,
  output logic [DW-1:0] ctrl2_word,
  output logic          pulse_reject,
  output logic [NCH-1:0] run_en,
  output logic [NCH-1:0] clk_ext,
  output logic [NCH-1:0] ovf_ie,
  output logic [NCH-1:0] pulse_en,
  output logic [NCH-1:0] start_stb,
  output logic [NCH-1:0] stop_stb
);
  localparam logic [DW-1:0] REJECT_MASK = DW'(low_pulse_mask(PULSE_FIRST));

  logic [DW-1:0]  new_word;
  logic [NCH-1:0] old_run, new_run, new_ext, new_ovf, new_pls;

  assign new_word     = wdata & ~REJECT_MASK;
  assign pulse_reject = wr_ctrl && |(wdata & REJECT_MASK);

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign old_run[g] = ctrl_word[g*NIB_W + BIT_RUN];
    assign new_run[g] = new_word[g*NIB_W + BIT_RUN];
    assign new_ext[g] = new_word[g*NIB_W + BIT_EXT];
    assign new_ovf[g] = new_word[g*NIB_W + BIT_OVF];
    assign new_pls[g] = new_word[g*NIB_W + BIT_PULSE];
  end

  // step 1: stop; step 2: configure; step 3: start
  logic [NCH-1:0] s1_clr, s1_set, s2_set, s3_set;
  logic [NCH-1:0] s1_ext, s1_ovf, s1_pls, s2_ext, s2_ovf, s2_pls;
  logic           s1_v, s2_v;
  logic [NCH-1:0] stop_now, start_now;

  assign stop_now  = s1_clr & run_en;
  assign start_now = s3_set & ~s1_clr & ~run_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_word  <= '0;
      ctrl2_word <= '0;
      s1_clr <= '0; s1_set <= '0; s2_set <= '0; s3_set <= '0;
      s1_ext <= '0; s1_ovf <= '0; s1_pls <= '0;
      s2_ext <= '0; s2_ovf <= '0; s2_pls <= '0;
      s1_v <= 1'b0; s2_v <= 1'b0;
      run_en <= '0; clk_ext <= '0; ovf_ie <= '0; pulse_en <= '0;
      start_stb <= '0; stop_stb <= '0;
    end else begin
      if (wr_ctrl2) ctrl2_word <= wdata;
      if (wr_ctrl) ctrl_word <= new_word;
      s1_v   <= wr_ctrl;
      s1_clr <= wr_ctrl ? (old_run & ~new_run) : '0;
      s1_set <= wr_ctrl ? (~old_run & new_run) : '0;
      s1_ext <= new_ext;
      s1_ovf <= new_ovf;
      s1_pls <= new_pls;
      s2_v   <= s1_v;
      s2_set <= s1_set;
      s2_ext <= s1_ext;
      s2_ovf <= s1_ovf;
      s2_pls <= s1_pls;
      s3_set <= s2_set;
      if (s2_v) begin
        clk_ext  <= s2_ext;
        ovf_ie   <= s2_ovf;
        pulse_en <= s2_pls;
      end
      run_en    <= (run_en | start_now) & ~s1_clr;
      stop_stb  <= stop_now;
      start_stb <= start_now;
    end
  end

  a_r6_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb & stop_stb) == '0);
  a_r5_stop_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb & run_en) == '0);
  a_r6_start_raises_run: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stb & ~run_en) == '0);
  a_r5_stop_only_if_running: assert property (@(posedge clk) disable iff (!rst_n)
    |stop_stb |=> ($past(stop_stb) & ~$past(run_en, 2)) == '0);
  a_r4_low_pulse_never: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_word & REJECT_MASK) == '0);
endmodule

// File: rtl/timer_bank_regs.sv
module timer_bank_regs
  import tbr_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 32,
  parameter int ADDR_W      = 8,
  parameter int LOW_BLOCKS  = 3,
  parameter int PULSE_FIRST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_err,
  input  logic [NCH*DW-1:0] cnt_live,
  output logic [NCH-1:0]    cnt_load,
  output logic [DW-1:0]     cnt_load_val,
  output logic [NCH*DW-1:0] reload_val,
  output logic [NCH*DW-1:0] match1_val,
  output logic [NCH*DW-1:0] match2_val,
  output logic [NCH-1:0]    run_en,
  output logic [NCH-1:0]    clk_ext,
  output logic [NCH-1:0]    ovf_irq_en,
  output logic [NCH-1:0]    pulse_en,
  output logic [NCH-1:0]    start_stb,
  output logic [NCH-1:0]    stop_stb
);
  localparam int CH_W = $clog2(NCH);

  acc_kind_e       acc_kind;
  logic [CH_W-1:0] acc_ch;
  chan_fld_e       acc_fld;
  logic [DW-1:0]   chan_rd, ctrl_word, ctrl2_word;
  logic            pulse_reject;
  logic            wr_chan, wr_ctrl, wr_ctrl2, rd_any, bad_acc;

  tbr_addr_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .LOW_BLOCKS(LOW_BLOCKS)) u_dec (
    .addr(bus_addr), .kind(acc_kind), .ch(acc_ch), .fld(acc_fld)
  );

  assign wr_chan  = bus_valid && bus_write && acc_kind == ACC_CHAN;
  assign wr_ctrl  = bus_valid && bus_write && acc_kind == ACC_CTRL;
  assign wr_ctrl2 = bus_valid && bus_write && acc_kind == ACC_CTRL2;
  assign rd_any   = bus_valid && !bus_write;
  assign bad_acc  = bus_valid && acc_kind == ACC_BAD;

  tbr_chan_file #(.NCH(NCH), .DW(DW)) u_chans (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_chan), .sel_ch(acc_ch), .sel_fld(acc_fld),
    .wdata(bus_wdata), .cnt_live(cnt_live), .reload_flat(reload_val),
    .match1_flat(match1_val), .match2_flat(match2_val), .cnt_load(cnt_load),
    .cnt_load_val(cnt_load_val), .rd_word(chan_rd)
  );

  tbr_ctrl_seq #(.NCH(NCH), .DW(DW), .PULSE_FIRST(PULSE_FIRST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_ctrl2(wr_ctrl2), .wdata(bus_wdata),
    .ctrl_word(ctrl_word), .ctrl2_word(ctrl2_word), .pulse_reject(pulse_reject),
    .run_en(run_en), .clk_ext(clk_ext), .ovf_ie(ovf_irq_en), .pulse_en(pulse_en),
    .start_stb(start_stb), .stop_stb(stop_stb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bad_acc || pulse_reject;
      if (rd_any) begin
        unique case (acc_kind)
          ACC_CHAN:  bus_rdata <= chan_rd;
          ACC_CTRL:  bus_rdata <= ctrl_word;
          ACC_CTRL2: bus_rdata <= ctrl2_word;
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  a_r8_bad_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> bus_err);
  a_r8_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_acc && !bus_write) |=> bus_rdata == '0);
  a_r7_ctrl2_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl2 |=> ($stable(run_en) && start_stb == '0 && stop_stb == '0));
endmodule

// File: tb/timer_bank_regs_bench.sv
`timescale 1ns/1ps
module timer_bank_regs_bench;
  localparam int NCH = 8;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [NCH*DW-1:0] cnt_live;
  logic [NCH-1:0] cnt_load, run_en, clk_ext, ovf_irq_en, pulse_en, start_stb, stop_stb;
  logic [31:0] cnt_load_val;
  logic [NCH*DW-1:0] reload_val, match1_val, match2_val;

  int checks = 0, fails = 0, cycles = 0;
  logic [23:0] stamp = 24'h000001;
  logic [31:0] m_reload [NCH], m_m1 [NCH], m_m2 [NCH];
  logic [31:0] m_ctrl = '0, m_ctrl2 = '0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++) cnt_live[i*DW +: DW] = {8'(i + 8'hA0), stamp};

  timer_bank_regs u_timer_bank_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .cnt_live(cnt_live), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .reload_val(reload_val), .match1_val(match1_val), .match2_val(match2_val),
    .run_en(run_en), .clk_ext(clk_ext), .ovf_irq_en(ovf_irq_en), .pulse_en(pulse_en),
    .start_stb(start_stb), .stop_stb(stop_stb)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // -1 bad, -2 control, -3 second control, else channel*4 + field
  function automatic int model_map(input logic [7:0] a);
    if (a % 4 != 0) return -1;
    if (a < 8'h30) return (a / 16) * 4 + (a % 16) / 4;
    if (a == 8'h30) return -2;
    if (a == 8'h34) return -3;
    if (a >= 8'h40 && a < 8'h90) return (a / 16 - 1) * 4 + (a % 16) / 4;
    return -1;
  endfunction

  function automatic logic [NCH-1:0] nib(input logic [31:0] w, input int b);
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = w[i*4 + b];
    return v;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int m;
    m = model_map(a);
    if (m == -1) return 0;
    if (m == -2) return m_ctrl;
    if (m == -3) return m_ctrl2;
    case (m % 4)
      0: return {8'(m / 4 + 8'hA0), stamp};
      1: return m_reload[m / 4];
      2: return m_m1[m / 4];
      default: return m_m2[m / 4];
    endcase
  endfunction

  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] e;
    e = model_read(a);
    access(1'b0, a, 32'h0);
    check(bus_rdata == e, tag, bus_rdata, e);
    check(bus_err == (model_map(a) == -1), {tag, " err"}, bus_err, model_map(a) == -1);
  endtask

  task automatic outputs_chk(input string tag);
    for (int i = 0; i < NCH; i++) begin
      check(reload_val[i*DW +: DW] == m_reload[i], {tag, " reload out"}, reload_val[i*DW +: DW], m_reload[i]);
      check(match1_val[i*DW +: DW] == m_m1[i], {tag, " match1 out"}, match1_val[i*DW +: DW], m_m1[i]);
      check(match2_val[i*DW +: DW] == m_m2[i], {tag, " match2 out"}, match2_val[i*DW +: DW], m_m2[i]);
    end
  endtask

  task automatic chan_wr(input logic [7:0] a, input logic [31:0] d);
    int m;
    m = model_map(a);
    access(1'b1, a, d);
    case (m % 4)
      0: begin
        check(cnt_load == NCH'(1) << (m / 4), "R2 load strobe", cnt_load, NCH'(1) << (m / 4));
        check(cnt_load_val == d, "R2 load value", cnt_load_val, d);
        @(negedge clk);
        check(cnt_load == '0, "R2 load one cycle", cnt_load, 0);
      end
      1: m_reload[m / 4] = d;
      2: m_m1[m / 4] = d;
      default: m_m2[m / 4] = d;
    endcase
    check(bus_err == 1'b0 || m % 4 == 0, "R1 no err", bus_err, 0);
    outputs_chk("R1");
  endtask

  task automatic ctrl_wr(input logic [31:0] w);
    logic [31:0] kept;
    logic [NCH-1:0] o_run, n_run, o_ext, o_ovf, o_pls;
    bit rej;
    kept = w & ~32'h0000_8888;
    rej = (w & 32'h0000_8888) != 0;
    o_run = nib(m_ctrl, 0); n_run = nib(kept, 0);
    o_ext = nib(m_ctrl, 1); o_ovf = nib(m_ctrl, 2); o_pls = nib(m_ctrl, 3);
    access(1'b1, 8'h30, w);
    check(bus_err == rej, "R4 reject flag", bus_err, rej);
    m_ctrl = kept;
    @(negedge clk);
    check(stop_stb == (o_run & ~n_run), "R5 stop strobe", stop_stb, o_run & ~n_run);
    check(run_en == (o_run & n_run), "R5 run after stop", run_en, o_run & n_run);
    check({clk_ext, ovf_irq_en, pulse_en} == {o_ext, o_ovf, o_pls}, "R5 cfg still old",
          {clk_ext, ovf_irq_en, pulse_en}, {o_ext, o_ovf, o_pls});
    check(start_stb == '0, "R10 no early start", start_stb, 0);
    @(negedge clk);
    check({clk_ext, ovf_irq_en, pulse_en} == {nib(kept, 1), nib(kept, 2), nib(kept, 3)},
          "R6 cfg applied", {clk_ext, ovf_irq_en, pulse_en}, {nib(kept, 1), nib(kept, 2), nib(kept, 3)});
    check(pulse_en[3:0] == 4'h0, "R4 low pulse off", pulse_en, 0);
    check(run_en == (o_run & n_run), "R6 not yet started", run_en, o_run & n_run);
    check(stop_stb == '0, "R10 stop one cycle", stop_stb, 0);
    @(negedge clk);
    check(run_en == n_run, "R6 run applied", run_en, n_run);
    check(start_stb == (~o_run & n_run), "R6 start strobe", start_stb, ~o_run & n_run);
    @(negedge clk);
    check(start_stb == '0, "R10 start one cycle", start_stb, 0);
    rd_chk(8'h30, "R3 ctrl readback");
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin m_reload[i] = 0; m_m1[i] = 0; m_m2[i] = 0; end
    void'($urandom(32'h5EED_7177));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(bus_rdata == 0 && bus_err == 0, "R9 bus idle", {bus_rdata, bus_err}, 0);
    check({run_en, clk_ext, ovf_irq_en, pulse_en, start_stb, stop_stb, cnt_load} == 0,
          "R9 channel outputs", {run_en, clk_ext, ovf_irq_en, pulse_en}, 0);
    outputs_chk("R9");
    rd_chk(8'h30, "R9 ctrl zero");
    rd_chk(8'h34, "R9 ctrl2 zero");
    rd_chk(8'h84, "R9 reload zero");

    // directed map corners R1
    chan_wr(8'h24, 32'h1111_0002);
    chan_wr(8'h44, 32'h3333_0003);
    chan_wr(8'h8C, 32'h8888_0007);
    chan_wr(8'h08, 32'h0000_00AA);
    rd_chk(8'h24, "R1 ch2 reload");
    rd_chk(8'h44, "R1 ch3 reload");
    rd_chk(8'h8C, "R1 ch7 match2");
    rd_chk(8'h08, "R1 ch0 match1");
    chan_wr(8'h50, 32'hDEAD_BEEF);
    rd_chk(8'h50, "R2 count live read");

    // illegal offsets R8
    access(1'b1, 8'h38, 32'hFFFF_FFFF);
    check(bus_err == 1'b1, "R8 err 0x38", bus_err, 1);
    @(negedge clk);
    check(bus_err == 1'b0, "R8 err one cycle", bus_err, 0);
    access(1'b1, 8'h45, 32'hFFFF_FFFF);
    check(bus_err == 1'b1, "R8 err misaligned", bus_err, 1);
    access(1'b1, 8'h90, 32'hFFFF_FFFF);
    outputs_chk("R8");
    rd_chk(8'h3C, "R8 read 0x3C");
    rd_chk(8'h44, "R8 write ignored");
    rd_chk(8'hF0, "R8 read high");

    // control sequencing R3..R6, R10
    ctrl_wr(32'h0000_0001);
    ctrl_wr(32'h5432_10F7);
    ctrl_wr(32'h5432_10F7);
    ctrl_wr(32'hF0F0_0F0E);
    ctrl_wr(32'h0000_0000);

    // R7 second control word
    begin
      logic [NCH-1:0] r0;
      r0 = run_en;
      access(1'b1, 8'h34, 32'hCAFE_F00D);
      m_ctrl2 = 32'hCAFE_F00D;
      repeat (3) @(negedge clk);
      check(run_en == r0 && start_stb == 0 && stop_stb == 0, "R7 no effect", run_en, r0);
      rd_chk(8'h34, "R7 readback");
    end

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      int op;
      stamp = 24'($urandom);
      a = 8'($urandom);
      d = $urandom;
      op = int'($urandom % 10);
      if (op < 4) begin
        a = {a[7:2], 2'b00};
        if (model_map(a) >= 0) chan_wr(a, d);
        else rd_chk(a, "R8 random bad");
      end else if (op < 8) begin
        rd_chk(a, "R1 random read");
      end else if (op == 8) begin
        ctrl_wr(d);
      end else begin
        access(1'b1, a, d);
        if (model_map(a) == -1) begin
          check(bus_err == 1'b1, "R8 random write err", bus_err, 1);
          outputs_chk("R8");
        end else if (model_map(a) == -3) begin
          m_ctrl2 = d;
        end else if (model_map(a) == -2) begin
          m_ctrl = d & ~32'h0000_8888;
          repeat (4) @(negedge clk);
          check(run_en == nib(m_ctrl, 0), "R6 random run", run_en, nib(m_ctrl, 0));
        end else if (model_map(a) % 4 == 1) m_reload[model_map(a) / 4] = d;
        else if (model_map(a) % 4 == 2) m_m1[model_map(a) / 4] = d;
        else if (model_map(a) % 4 == 3) m_m2[model_map(a) / 4] = d;
        @(negedge clk);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule